// File: doc/BRIEF.md
# Completion Interrupt Coalescer

This block decides when a DMA channel should interrupt its host. Rather than raising a line for every finished packet, it counts completions down from a programmable threshold and flags a completion interrupt only when that count runs out. It also runs a restartable inactivity timer. Every completion reloads the timer, and if no further completion arrives before it drains, a delay interrupt is flagged. That interrupt catches the tail of a burst that never reached the threshold.

The register file feeds the block. It supplies a strobe for each write of the control register, the threshold and delay fields taken from that register, the three interrupt enables, and a write-one-to-clear strobe with its bit mask for the status register. The datapath supplies a one-cycle pulse per finished packet and an optional fault event. A prescaler supplies a tick strobe that paces the timer. The block returns the three pending bits, a level interrupt, and the live counter and timer values so that status reads can show them. A build parameter can remove the delay timer entirely. The timer then reads as zero and never fires.

Top module: `irq_coalesce`

## Requirements
- R1: After reset, pending bits are 000, the interrupt is low, the live timer is 0 and the live counter holds RST_LOAD (default 1).
- R2: A control write strobe loads the counter from the threshold input on the next edge. A completion pulse in the same cycle is not counted.
- R3: Each completion pulse without a control write decrements the counter. A completion that finds the counter at 1 sets pending bit 0 (completion interrupt) and reloads the threshold instead. A counter at 0 wraps to all ones, so a threshold of 0 means 2^CNT_W completions.
- R4: A completion pulse with a non-zero delay field loads the timer with that delay, overriding any tick in that cycle. A completion with a zero delay field leaves the timer running as it was.
- R5: While the timer is non-zero it drops by one on each tick strobe. Without a tick or a restart it keeps its value, and at 0 it stays stopped.
- R6: A tick that finds the timer at 1 with no restart stops it at 0 and sets pending bit 1 (delay interrupt). It also reloads the counter from the threshold unless a control write or a completion acts on the counter in that cycle.
- R7: The fault event input sets pending bit 2.
- R8: A clear strobe clears each pending bit whose mask bit is 1. A set event on the same bit in the same cycle wins and leaves it 1.
- R9: The interrupt output is high exactly when some pending bit and its enable bit are both 1. It follows the pending and enable values with no extra register.
- R10: The live counter and live timer outputs show the present internal counts in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_wr | input | 1 | Control register write strobe |
| cfg_thresh | input | CNT_W | Completion threshold field |
| cfg_delay | input | TMR_W | Delay timeout field |
| cfg_irq_en | input | 3 | Interrupt enables, one per pending bit |
| sts_clr | input | 1 | Status write-one-to-clear strobe |
| sts_clr_mask | input | 3 | Bits to clear with sts_clr |
| pkt_done | input | 1 | One pulse per finished packet |
| fault_evt | input | 1 | Sets pending bit 2 |
| tick | input | 1 | Timer decrement strobe |
| pend | output | 3 | Pending bits: 0 completion, 1 delay, 2 fault |
| live_count | output | CNT_W | Present completion counter |
| live_timer | output | TMR_W | Present delay timer |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with CNT_W=4, TMR_W=5 and the delay timer present. The narrow counter lets a zero threshold wrap through all 16 completions in a short directed run. The small delay values make the timer drain often enough under random ticks to produce many expiries. These settings also bring the contested cycles within reach: expiry against restart, completion against control write, and clear against set.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam int PEND_W   = 3;
   localparam int IDX_CMPL = 0;
   localparam int IDX_DLY  = 1;
   localparam int IDX_ERR  = 2;
   typedef logic [PEND_W-1:0] pend_t;
endpackage

// File: rtl/irqc_cmpl_counter.sv
module irqc_cmpl_counter #(
   parameter int CNT_W    = 8,
   parameter int RST_LOAD = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] thresh_i,
   input  logic             done_i,
   input  logic             reload_i,
   output logic [CNT_W-1:0] count_o,
   output logic             hit_o
);
   localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
   localparam logic [CNT_W-1:0] RST_VAL = CNT_W'(RST_LOAD);

   generate
      if (CNT_W < 1 || CNT_W > 16) begin : g_bad_w
         $error("irqc_cmpl_counter: CNT_W out of range");
      end
      if (RST_LOAD < 0 || RST_LOAD >= (1 << CNT_W)) begin : g_bad_rst
         $error("irqc_cmpl_counter: RST_LOAD does not fit CNT_W");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   assign hit_o   = done_i && !load_i && (cnt_q == ONE);
   assign count_o = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)        cnt_q <= RST_VAL;
      else if (load_i)   cnt_q <= thresh_i;
      else if (done_i)   cnt_q <= (cnt_q == ONE) ? thresh_i : cnt_q - ONE;
      else if (reload_i) cnt_q <= thresh_i;
   end

   assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (cnt_q == $past(thresh_i)));

   assert_decrement_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && !load_i && cnt_q != ONE) |=> (cnt_q == $past(cnt_q) - ONE));

   assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !done_i && !reload_i) |=> $stable(cnt_q));
endmodule

// File: rtl/irqc_delay_timer.sv
module irqc_delay_timer #(
   parameter int TMR_W     = 8,
   parameter bit HAS_DELAY = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             done_i,
   input  logic [TMR_W-1:0] delay_i,
   input  logic             tick_i,
   output logic [TMR_W-1:0] timer_o,
   output logic             expire_o
);
   localparam logic [TMR_W-1:0] ONE  = TMR_W'(1);
   localparam logic [TMR_W-1:0] ZERO = '0;

   generate
      if (TMR_W < 1 || TMR_W > 16) begin : g_bad_w
         $error("irqc_delay_timer: TMR_W out of range");
      end

      if (HAS_DELAY) begin : g_timer
         logic [TMR_W-1:0] tmr_q;
         logic             restart;

         assign restart  = done_i && (delay_i != ZERO);
         assign expire_o = !restart && tick_i && (tmr_q == ONE);
         assign timer_o  = tmr_q;

         always_ff @(posedge clk) begin
            if (!rst_n)                           tmr_q <= ZERO;
            else if (restart)                     tmr_q <= delay_i;
            else if (tick_i && tmr_q != ZERO)     tmr_q <= tmr_q - ONE;
         end

         assert_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (done_i && delay_i != ZERO) |=> (tmr_q == $past(delay_i)));

         assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (!tick_i && !(done_i && delay_i != ZERO)) |=> $stable(tmr_q));

         assert_stopped_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (tmr_q == ZERO && !(done_i && delay_i != ZERO)) |=> (tmr_q == ZERO));
      end else begin : g_no_timer
         logic unused_in;
         assign unused_in = done_i ^ tick_i ^ (^delay_i) ^ clk ^ rst_n;
         assign timer_o   = ZERO;
         assign expire_o  = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/irqc_pending.sv
module irqc_pending
   import irqc_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  pend_t set_i,
   input  logic  clr_i,
   input  pend_t clr_mask_i,
   input  pend_t en_i,
   output pend_t pend_o,
   output logic  irq_o
);
   pend_t pend_q;
   pend_t clr_eff;

   assign clr_eff = clr_i ? clr_mask_i : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~clr_eff) | set_i;
   end

   assign pend_o = pend_q;
   assign irq_o  = |(pend_q & en_i);

   assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i != '0) |=> ((pend_q & $past(set_i)) == $past(set_i)));

   assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> ((pend_q & $past(clr_mask_i & ~set_i)) == '0));

   assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_i |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
endmodule

// File: rtl/irq_coalesce.sv
module irq_coalesce
   import irqc_pkg::*;
#(
   parameter int CNT_W     = 8,
   parameter int TMR_W     = 8,
   parameter int RST_LOAD  = 1,
   parameter bit HAS_DELAY = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctrl_wr,
   input  logic [CNT_W-1:0] cfg_thresh,
   input  logic [TMR_W-1:0] cfg_delay,
   input  logic [2:0]       cfg_irq_en,
   input  logic             sts_clr,
   input  logic [2:0]       sts_clr_mask,
   input  logic             pkt_done,
   input  logic             fault_evt,
   input  logic             tick,
   output logic [2:0]       pend,
   output logic [CNT_W-1:0] live_count,
   output logic [TMR_W-1:0] live_timer,
   output logic             irq
);
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
   localparam logic [TMR_W-1:0] TMR_ONE = TMR_W'(1);

   logic  cnt_hit;
   logic  tmr_expire;
   pend_t set_vec;

   irqc_cmpl_counter #(.CNT_W(CNT_W), .RST_LOAD(RST_LOAD)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (ctrl_wr),
      .thresh_i (cfg_thresh),
      .done_i   (pkt_done),
      .reload_i (tmr_expire),
      .count_o  (live_count),
      .hit_o    (cnt_hit)
   );

   irqc_delay_timer #(.TMR_W(TMR_W), .HAS_DELAY(HAS_DELAY)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .done_i   (pkt_done),
      .delay_i  (cfg_delay),
      .tick_i   (tick),
      .timer_o  (live_timer),
      .expire_o (tmr_expire)
   );

   always_comb begin
      set_vec           = '0;
      set_vec[IDX_CMPL] = cnt_hit;
      set_vec[IDX_DLY]  = tmr_expire;
      set_vec[IDX_ERR]  = fault_evt;
   end

   irqc_pending u_pend (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_i      (set_vec),
      .clr_i      (sts_clr),
      .clr_mask_i (sts_clr_mask),
      .en_i       (cfg_irq_en),
      .pend_o     (pend),
      .irq_o      (irq)
   );

   assert_threshold_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_done && !ctrl_wr && live_count == CNT_ONE) |=> pend[IDX_CMPL]);

   assert_expiry_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && live_timer == TMR_ONE && !(pkt_done && cfg_delay != '0))
         |=> (pend[IDX_DLY] && live_timer == '0));

   assert_fault_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fault_evt |=> pend[IDX_ERR]);
endmodule

// File: tb/irq_coalesce_test.sv
`timescale 1ns/1ps
module irq_coalesce_test;
   localparam int CW = 4;
   localparam int TW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ctrl_wr = 0, sts_clr = 0, pkt_done = 0, fault_evt = 0, tick = 0;
   logic [CW-1:0] cfg_thresh = '0;
   logic [TW-1:0] cfg_delay = '0;
   logic [2:0]    cfg_irq_en = '0, sts_clr_mask = '0;
   logic [2:0]    pend;
   logic [CW-1:0] live_count;
   logic [TW-1:0] live_timer;
   logic          irq;

   int n_run = 0, n_fail = 0;
   bit done_flag = 0;

   logic [CW-1:0] m_cnt;
   logic [TW-1:0] m_tmr;
   logic [2:0]    m_pend;

   always #2.5 clk = ~clk;

   irq_coalesce #(.CNT_W(CW), .TMR_W(TW), .RST_LOAD(1), .HAS_DELAY(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .cfg_thresh(cfg_thresh),
      .cfg_delay(cfg_delay), .cfg_irq_en(cfg_irq_en), .sts_clr(sts_clr),
      .sts_clr_mask(sts_clr_mask), .pkt_done(pkt_done), .fault_evt(fault_evt),
      .tick(tick), .pend(pend), .live_count(live_count), .live_timer(live_timer),
      .irq(irq));

   task automatic chk(string tag, string what, int act, int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic check_all(string tc, string tt, string tp, string ti);
      chk(tc, "live_count", int'(live_count), int'(m_cnt));
      chk(tt, "live_timer", int'(live_timer), int'(m_tmr));
      chk(tp, "pend", int'(pend), int'(m_pend));
      chk(ti, "irq", int'(irq), int'(|(m_pend & cfg_irq_en)));
   endtask

   // Reference model of one clock edge, from the requirements.
   task automatic model_edge();
      logic restart, expire, hit;
      logic [2:0] clr;
      restart = pkt_done && (cfg_delay != '0);
      expire  = !restart && tick && (m_tmr == TW'(1));
      hit     = !ctrl_wr && pkt_done && (m_cnt == CW'(1));
      clr     = sts_clr ? sts_clr_mask : 3'b000;
      m_pend  = (m_pend & ~clr) | {fault_evt, expire, hit};
      if (ctrl_wr)       m_cnt = cfg_thresh;
      else if (pkt_done) m_cnt = (m_cnt == CW'(1)) ? cfg_thresh : m_cnt - CW'(1);
      else if (expire)   m_cnt = cfg_thresh;
      if (restart)                   m_tmr = cfg_delay;
      else if (tick && m_tmr != '0)  m_tmr = m_tmr - TW'(1);
   endtask

   task automatic step(string tc, string tt, string tp, string ti);
      @(posedge clk);
      model_edge();
      @(negedge clk);
      check_all(tc, tt, tp, ti);
      ctrl_wr = 0; sts_clr = 0; pkt_done = 0; fault_evt = 0; tick = 0;
   endtask

   task automatic step1(string t);
      step(t, t, t, t);
   endtask

   initial begin
      #(200000 * 5);
      if (!done_flag) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      m_cnt = CW'(1); m_tmr = '0; m_pend = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cfg_irq_en = 3'b111;
      check_all("R1", "R1", "R1", "R1");

      // R2: control write loads, same-cycle completion not counted
      cfg_thresh = CW'(3); ctrl_wr = 1; step1("R2");
      cfg_thresh = CW'(2); ctrl_wr = 1; pkt_done = 1; step1("R2");
      // R3: count down to a hit
      pkt_done = 1; step1("R3");
      pkt_done = 1; step1("R3");
      chk("R3", "pend cmpl", int'(pend[0]), 1);
      sts_clr = 1; sts_clr_mask = 3'b001; step1("R8");
      // R3: zero threshold wraps through 2^CW completions
      cfg_thresh = '0; ctrl_wr = 1; step1("R3");
      for (int i = 0; i < (1 << CW); i++) begin
         pkt_done = 1; step1("R3");
      end
      chk("R3", "wrap hit", int'(pend[0]), 1);
      // R4/R5/R6: restart, hold, expiry
      cfg_thresh = CW'(5); ctrl_wr = 1; sts_clr = 1; sts_clr_mask = 3'b111; step1("R8");
      cfg_delay = TW'(3); pkt_done = 1; step1("R4");
      chk("R4", "timer loaded", int'(live_timer), 3);
      step1("R5");
      tick = 1; step1("R5");
      cfg_delay = '0; pkt_done = 1; tick = 1; step1("R4");
      chk("R10", "live timer", int'(live_timer), 1);
      tick = 1; step1("R6");
      chk("R6", "delay pend", int'(pend[1]), 1);
      chk("R6", "count reload", int'(live_count), 5);
      tick = 1; step1("R5");
      // R6: restart beats expiry
      cfg_delay = TW'(1); pkt_done = 1; step1("R4");
      cfg_delay = TW'(2); pkt_done = 1; tick = 1; sts_clr = 1; sts_clr_mask = 3'b010; step1("R6");
      chk("R6", "no expiry on restart", int'(pend[1]), 0);
      // R7/R8: fault and set-wins
      fault_evt = 1; step1("R7");
      fault_evt = 1; sts_clr = 1; sts_clr_mask = 3'b100; step1("R8");
      chk("R8", "set wins", int'(pend[2]), 1);
      // R9: enable masking
      cfg_irq_en = 3'b011; #1; check_all("R9", "R9", "R9", "R9");
      cfg_irq_en = 3'b100; #1; check_all("R9", "R9", "R9", "R9");

      // Constrained random mix
      for (int k = 0; k < 5000; k++) begin
         ctrl_wr    = ($urandom % 20) == 0;
         cfg_thresh = CW'($urandom % 4);
         cfg_delay  = TW'($urandom % 5);
         cfg_irq_en = 3'($urandom);
         pkt_done   = ($urandom % 3) == 0;
         tick       = ($urandom % 2) == 0;
         fault_evt  = ($urandom % 40) == 0;
         sts_clr    = ($urandom % 6) == 0;
         sts_clr_mask = 3'($urandom);
         step("R3", "R5", "R8", "R9");
      end
      done_flag = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule